// File: doc/BRIEF.md
# Ordered Multi-Entry Request Dispatcher

The dispatcher takes read and write requests from an upstream port and holds each one in one of `N` independent slots (eight by default). Every slot runs a small state machine: it sends its request on one shared downstream request channel, waits for the downstream responses, and then returns a completion on one shared upstream response channel. The slot index is the transaction ID of the request on the downstream side, and every downstream response is routed back to its slot by that ID.

Reads are ordered. Once a slot has sent a read, it waits for a read receipt. While any slot waits for a receipt, no slot may send a new read. Writes are not held back by this rule. Two round-robin arbiters share out the downstream request channel and the upstream response channel among the slots that are ready to use them.

Each slot has four states. The transitions are:
- `SLOT_IDLE` to `SLOT_ISSUE` on allocation.
- `SLOT_ISSUE` to `SLOT_WAIT` when its request is accepted downstream.
- `SLOT_WAIT` back to `SLOT_ISSUE` on a retry.
- `SLOT_WAIT` to `SLOT_REPLY` once every expected response has arrived.
- `SLOT_REPLY` to `SLOT_IDLE` when its completion is accepted upstream.

Top module: `ordered_dispatch`

## Requirements
- R1: During and right after reset:
    - every slot is free;
    - `up_ready` is 1;
    - `txreq_valid` is 0;
    - `dn_valid` is 0.
- R2: An upstream request is accepted on a clock edge where `up_valid` and `up_ready` are both high. It goes into the lowest-indexed free slot. From the next cycle, that slot can present the request downstream with `txreq_txnid` equal to the slot index. The request carries the stored address, and the stored write data for writes (0 for reads).
- R3: `up_ready` is 0 exactly when all `N` slots are busy. In that case, a request on `up_valid` is not accepted.
- R4: While any slot waits for a read receipt, no read (`txreq_write`=0) is presented downstream. Writes are presented regardless of this.
- R5: A read accepted downstream (`txreq_valid` and `txreq_ready`) marks its slot as waiting for a receipt from the next cycle. At most one request leaves per cycle.
- R6: The downstream request channel is granted round-robin. The slots that may take part are:
    - slots in `SLOT_ISSUE` that are writes;
    - slots in `SLOT_ISSUE` that are reads, when no receipt is pending.
  The search starts at the slot after the last accepted winner and wraps around. After reset it starts at slot 0. The grant does not move while `txreq_ready` is low.
- R7: A response goes to the slot whose index equals `rx_txnid`. `rx_kind` encodes the response as follows: 0 is a read receipt, 1 is read data, 2 is a write completion and 3 is a retry. A read slot goes to `SLOT_REPLY` once it has both the receipt and the data, in either order. A write slot goes to `SLOT_REPLY` on its completion.
- R8: A retry sent to a waiting slot clears everything that slot is waiting for and returns it to `SLOT_ISSUE`. The slot then re-presents the same transaction ID, address and data.
- R9: The upstream response channel is granted round-robin among slots in `SLOT_REPLY`, with the same pointer rule as R6. The completion carries:
    - `dn_id`, the slot index;
    - `dn_write`, the write flag;
    - `dn_data`, the first read data received for reads, or 0 for writes.
  When `dn_ready` accepts the completion, the slot is freed.
- R10: The following responses have no effect on any output:
    - a response to a slot that is not in `SLOT_WAIT`;
    - a response of a kind the slot is not waiting for, which includes repeated read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream request present |
| up_ready | output | 1 | A free slot exists |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | ADDR_W | Request address |
| up_wdata | input | DATA_W | Write data |
| txreq_valid | output | 1 | Downstream request present |
| txreq_ready | input | 1 | Downstream accepts the request |
| txreq_txnid | output | $clog2(N) | Transaction ID (slot index) |
| txreq_write | output | 1 | Request is a write |
| txreq_addr | output | ADDR_W | Request address |
| txreq_wdata | output | DATA_W | Write data (0 for reads) |
| rx_valid | input | 1 | Downstream response present |
| rx_txnid | input | $clog2(N) | Transaction ID of the response |
| rx_kind | input | 2 | 0 receipt, 1 read data, 2 write completion, 3 retry |
| rx_data | input | DATA_W | Read data |
| dn_valid | output | 1 | Upstream completion present |
| dn_ready | input | 1 | Upstream accepts the completion |
| dn_id | output | $clog2(N) | Slot that completes |
| dn_write | output | 1 | Completion is for a write |
| dn_data | output | DATA_W | Read data (0 for writes) |

## Verification
Every output is driven from registered slot state and arbiter pointers only, so each result shows up exactly one cycle after the edge that caused it:
- an accepted request appears on `txreq_*` in the cycle after acceptance;
- the receipt gate closes in the cycle after a read leaves;
- a final response puts the completion on `dn_*` in the cycle after the response edge.

The bench drives inputs and compares at the falling edge. Its model works out the outputs for that cycle from its own slot list. It then advances by one step at the rising edge, using the inputs and grants it just checked. This way, every comparison falls in the cycle in which a result is due.

// File: rtl/odisp_pkg.sv
package odisp_pkg;

    // Life cycle of one request slot.
    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_ISSUE = 2'd1,
        SLOT_WAIT  = 2'd2,
        SLOT_REPLY = 2'd3
    } slot_state_e;

    // Downstream response kinds as coded on rx_kind.
    typedef enum logic [1:0] {
        RX_RECEIPT  = 2'd0,
        RX_COMPDATA = 2'd1,
        RX_COMP     = 2'd2,
        RX_RETRY    = 2'd3
    } rx_kind_e;

endpackage

// File: rtl/odisp_rr.sv
module odisp_rr #(
    parameter int N = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    input  logic                 take,
    output logic [N-1:0]         gnt,
    output logic [$clog2(N)-1:0] idx,
    output logic                 any
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] ptr_q;
    int            cand;

    // Search from the pointer upward, wrapping once.
    always_comb begin
        gnt  = '0;
        idx  = '0;
        any  = 1'b0;
        cand = 0;
        for (int k = 0; k < N; k++) begin
            cand = int'(ptr_q) + k;
            if (cand >= N) begin
                cand = cand - N;
            end
            if (!any && req[cand]) begin
                any       = 1'b1;
                gnt[cand] = 1'b1;
                idx       = IW'(cand);
            end
        end
    end

    // Advance past the winner only when the grant is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (take && any) begin
            ptr_q <= (idx == IW'(N - 1)) ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/odisp_slot.sv
module odisp_slot
    import odisp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              ld_write,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              tx_fire,
    input  logic              rx_hit,
    input  rx_kind_e          rx_kind,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              up_fire,
    output slot_state_e       state_o,
    output logic              is_write,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              rcpt_wait
);
    slot_state_e       state_q, state_d;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              rcpt_q, dat_q, comp_q;
    logic              rcpt_n, dat_n, comp_n;
    logic              in_wait, retry_hit, all_done;

    // Outstanding-response bookkeeping for the WAIT state.
    always_comb begin
        in_wait   = (state_q == SLOT_WAIT);
        retry_hit = in_wait && rx_hit && (rx_kind == RX_RETRY);
        rcpt_n    = rcpt_q && !retry_hit && !(in_wait && rx_hit && rx_kind == RX_RECEIPT);
        dat_n     = dat_q  && !retry_hit && !(in_wait && rx_hit && rx_kind == RX_COMPDATA);
        comp_n    = comp_q && !retry_hit && !(in_wait && rx_hit && rx_kind == RX_COMP);
        all_done  = !rcpt_n && !dat_n && !comp_n;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE:  if (load)    state_d = SLOT_ISSUE;
            SLOT_ISSUE: if (tx_fire) state_d = SLOT_WAIT;
            SLOT_WAIT: begin
                if (retry_hit) begin
                    state_d = SLOT_ISSUE;
                end else if (all_done) begin
                    state_d = SLOT_REPLY;
                end
            end
            SLOT_REPLY: if (up_fire) state_d = SLOT_IDLE;
            default:    state_d = SLOT_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Payload and pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            rcpt_q <= 1'b0;
            dat_q  <= 1'b0;
            comp_q <= 1'b0;
        end else begin
            if (state_q == SLOT_IDLE && load) begin
                wr_q   <= ld_write;
                addr_q <= ld_addr;
                data_q <= ld_data;
            end
            if (state_q == SLOT_ISSUE && tx_fire) begin
                rcpt_q <= !wr_q;
                dat_q  <= !wr_q;
                comp_q <= wr_q;
            end else if (in_wait) begin
                rcpt_q <= rcpt_n;
                dat_q  <= dat_n;
                comp_q <= comp_n;
                if (rx_hit && rx_kind == RX_COMPDATA && dat_q) begin
                    data_q <= rx_data;
                end
            end
        end
    end

    assign state_o   = state_q;
    assign is_write  = wr_q;
    assign addr_o    = addr_q;
    assign data_o    = data_q;
    assign rcpt_wait = rcpt_q;

endmodule

// File: rtl/ordered_dispatch.sv
module ordered_dispatch
    import odisp_pkg::*;
#(
    parameter int N      = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 up_valid,
    output logic                 up_ready,
    input  logic                 up_write,
    input  logic [ADDR_W-1:0]    up_addr,
    input  logic [DATA_W-1:0]    up_wdata,
    output logic                 txreq_valid,
    input  logic                 txreq_ready,
    output logic [$clog2(N)-1:0] txreq_txnid,
    output logic                 txreq_write,
    output logic [ADDR_W-1:0]    txreq_addr,
    output logic [DATA_W-1:0]    txreq_wdata,
    input  logic                 rx_valid,
    input  logic [$clog2(N)-1:0] rx_txnid,
    input  logic [1:0]           rx_kind,
    input  logic [DATA_W-1:0]    rx_data,
    output logic                 dn_valid,
    input  logic                 dn_ready,
    output logic [$clog2(N)-1:0] dn_id,
    output logic                 dn_write,
    output logic [DATA_W-1:0]    dn_data
);
    localparam int IW = $clog2(N);

    slot_state_e       st     [N];
    logic [ADDR_W-1:0] addr_a [N];
    logic [DATA_W-1:0] data_a [N];
    logic [N-1:0]      wr_v, rcpt_v, busy;
    logic [N-1:0]      tx_req, tx_gnt, dn_req, dn_gnt;
    logic [N-1:0]      load_v, tx_fire_v, dn_fire_v, hit_v;
    logic [IW-1:0]     alloc_idx, tx_idx, dn_idx;
    logic              any_free, tx_any, dn_any, rd_block;
    rx_kind_e          kind;

    assign kind     = rx_kind_e'(rx_kind);
    assign rd_block = |rcpt_v;
    assign up_ready = any_free;

    // Lowest-indexed free slot.
    always_comb begin
        any_free  = 1'b0;
        alloc_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free  = 1'b1;
                alloc_idx = IW'(i);
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_slot
        assign busy[g]      = (st[g] != SLOT_IDLE);
        assign tx_req[g]    = (st[g] == SLOT_ISSUE) && (wr_v[g] || !rd_block);
        assign dn_req[g]    = (st[g] == SLOT_REPLY);
        assign load_v[g]    = up_valid && any_free && (alloc_idx == IW'(g));
        assign tx_fire_v[g] = tx_gnt[g] && txreq_ready;
        assign dn_fire_v[g] = dn_gnt[g] && dn_ready;
        assign hit_v[g]     = rx_valid && (rx_txnid == IW'(g));

        odisp_slot #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load_v[g]),
            .ld_write  (up_write),
            .ld_addr   (up_addr),
            .ld_data   (up_wdata),
            .tx_fire   (tx_fire_v[g]),
            .rx_hit    (hit_v[g]),
            .rx_kind   (kind),
            .rx_data   (rx_data),
            .up_fire   (dn_fire_v[g]),
            .state_o   (st[g]),
            .is_write  (wr_v[g]),
            .addr_o    (addr_a[g]),
            .data_o    (data_a[g]),
            .rcpt_wait (rcpt_v[g])
        );
    end

    odisp_rr #(.N(N)) u_tx_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (tx_req),
        .take  (txreq_ready),
        .gnt   (tx_gnt),
        .idx   (tx_idx),
        .any   (tx_any)
    );

    odisp_rr #(.N(N)) u_dn_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (dn_req),
        .take  (dn_ready),
        .gnt   (dn_gnt),
        .idx   (dn_idx),
        .any   (dn_any)
    );

    // Output steering from the winning slots.
    always_comb begin
        txreq_valid = tx_any;
        txreq_txnid = tx_idx;
        txreq_write = wr_v[tx_idx];
        txreq_addr  = addr_a[tx_idx];
        txreq_wdata = wr_v[tx_idx] ? data_a[tx_idx] : '0;
        dn_valid    = dn_any;
        dn_id       = dn_idx;
        dn_write    = wr_v[dn_idx];
        dn_data     = wr_v[dn_idx] ? '0 : data_a[dn_idx];
    end

endmodule

// File: rtl/odisp_chk.sv
module odisp_chk #(
    parameter int N = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 up_valid,
    input logic                 up_ready,
    input logic [$clog2(N)-1:0] alloc_idx,
    input logic [N-1:0]         busy,
    input logic                 txreq_valid,
    input logic                 txreq_ready,
    input logic                 txreq_write,
    input logic [$clog2(N)-1:0] txreq_txnid,
    input logic [N-1:0]         rcpt_vec,
    input logic [N-1:0]         tx_gnt,
    input logic [N-1:0]         dn_gnt
);
    // R3
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy) |-> !up_ready);

    // R2
    alloc_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready) |=> busy[$past(alloc_idx)]);

    // R4
    read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txreq_valid && !txreq_write) |-> (rcpt_vec == '0));

    // R5
    rcpt_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txreq_valid && txreq_ready && !txreq_write) |=> rcpt_vec[$past(txreq_txnid)]);

    // R5
    no_read_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txreq_valid && txreq_ready && !txreq_write) |=> !(txreq_valid && !txreq_write));

    // R6
    tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_gnt));

    // R9
    dn_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dn_gnt));

endmodule

bind ordered_dispatch odisp_chk #(.N(N)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .up_valid    (up_valid),
    .up_ready    (up_ready),
    .alloc_idx   (alloc_idx),
    .busy        (busy),
    .txreq_valid (txreq_valid),
    .txreq_ready (txreq_ready),
    .txreq_write (txreq_write),
    .txreq_txnid (txreq_txnid),
    .rcpt_vec    (rcpt_v),
    .tx_gnt      (tx_gnt),
    .dn_gnt      (dn_gnt)
);

// File: tb/ordered_dispatch_bench.sv
module ordered_dispatch_bench;
    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          up_valid = 1'b0, up_write = 1'b0;
    logic [31:0]   up_addr = '0, up_wdata = '0;
    logic          up_ready;
    logic          txreq_valid, txreq_write;
    logic          txreq_ready = 1'b0;
    logic [IW-1:0] txreq_txnid;
    logic [31:0]   txreq_addr, txreq_wdata;
    logic          rx_valid = 1'b0;
    logic [IW-1:0] rx_txnid = '0;
    logic [1:0]    rx_kind = '0;
    logic [31:0]   rx_data = '0;
    logic          dn_valid, dn_write;
    logic          dn_ready = 1'b0;
    logic [IW-1:0] dn_id;
    logic [31:0]   dn_data;

    always #10 clk = ~clk;

    ordered_dispatch u_ordered_dispatch (
        .clk (clk), .rst_n (rst_n),
        .up_valid (up_valid), .up_ready (up_ready), .up_write (up_write),
        .up_addr (up_addr), .up_wdata (up_wdata),
        .txreq_valid (txreq_valid), .txreq_ready (txreq_ready),
        .txreq_txnid (txreq_txnid), .txreq_write (txreq_write),
        .txreq_addr (txreq_addr), .txreq_wdata (txreq_wdata),
        .rx_valid (rx_valid), .rx_txnid (rx_txnid), .rx_kind (rx_kind), .rx_data (rx_data),
        .dn_valid (dn_valid), .dn_ready (dn_ready), .dn_id (dn_id),
        .dn_write (dn_write), .dn_data (dn_data)
    );

    // Reference model: 0 free, 1 to send, 2 waiting, 3 to complete.
    int          st [N];
    bit          mrc [N], mdt [N], mcm [N], mwr [N];
    logic [31:0] mad [N], mda [N];
    int          tptr, dptr;
    int          n_run = 0, n_fail = 0, cycles = 0;
    bit          done = 1'b0;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            st[i] = 0; mrc[i] = 0; mdt[i] = 0; mcm[i] = 0; mwr[i] = 0; mad[i] = '0; mda[i] = '0;
        end
        tptr = 0;
        dptr = 0;
    endtask

    task automatic step(input string tag);
        int fi, tg, dg, rid, rk;
        bit blk, acc, tf, df, rv;
        logic [31:0] rd, ua, ud;
        bit uw;
        fi = -1; tg = -1; dg = -1; blk = 0;
        for (int i = 0; i < N; i++) begin
            if (st[i] == 0 && fi < 0) fi = i;
            if (mrc[i]) blk = 1;
        end
        for (int k = 0; k < N; k++) begin
            int c;
            c = (tptr + k) % N;
            if (tg < 0 && st[c] == 1 && (mwr[c] || !blk)) tg = c;
        end
        for (int k = 0; k < N; k++) begin
            int c;
            c = (dptr + k) % N;
            if (dg < 0 && st[c] == 3) dg = c;
        end
        chk(tag, "up_ready", up_ready, fi >= 0);
        chk(tag, "txreq_valid", txreq_valid, tg >= 0);
        if (tg >= 0) begin
            chk(tag, "txreq_txnid", txreq_txnid, tg);
            chk(tag, "txreq_write", txreq_write, mwr[tg]);
            chk(tag, "txreq_addr", txreq_addr, mad[tg]);
            chk(tag, "txreq_wdata", txreq_wdata, mwr[tg] ? mda[tg] : 32'h0);
        end
        chk(tag, "dn_valid", dn_valid, dg >= 0);
        if (dg >= 0) begin
            chk(tag, "dn_id", dn_id, dg);
            chk(tag, "dn_write", dn_write, mwr[dg]);
            chk(tag, "dn_data", dn_data, mwr[dg] ? 32'h0 : mda[dg]);
        end
        acc = up_valid && fi >= 0;
        uw = up_write; ua = up_addr; ud = up_wdata;
        tf = (tg >= 0) && txreq_ready;
        df = (dg >= 0) && dn_ready;
        rv = rx_valid; rid = int'(rx_txnid); rk = int'(rx_kind); rd = rx_data;
        @(posedge clk);
        if (rv && st[rid] == 2) begin
            if (rk == 3) begin
                st[rid] = 1; mrc[rid] = 0; mdt[rid] = 0; mcm[rid] = 0;
            end else if (rk == 0) begin
                mrc[rid] = 0;
            end else if (rk == 1) begin
                if (mdt[rid]) begin mda[rid] = rd; mdt[rid] = 0; end
            end else begin
                mcm[rid] = 0;
            end
            if (st[rid] == 2 && !mrc[rid] && !mdt[rid] && !mcm[rid]) st[rid] = 3;
        end
        if (tf) begin
            st[tg] = 2; mrc[tg] = !mwr[tg]; mdt[tg] = !mwr[tg]; mcm[tg] = mwr[tg];
            tptr = (tg + 1) % N;
        end
        if (df) begin
            st[dg] = 0;
            dptr = (dg + 1) % N;
        end
        if (acc) begin
            st[fi] = 1; mwr[fi] = uw; mad[fi] = ua; mda[fi] = ud;
        end
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input int n);
        repeat (n) step(tag);
    endtask

    task automatic send(input string tag, input bit w, input logic [31:0] a, input logic [31:0] d);
        up_valid = 1; up_write = w; up_addr = a; up_wdata = d;
        step(tag);
        up_valid = 0;
    endtask

    task automatic give(input string tag, input int id, input int kind, input logic [31:0] d);
        rx_valid = 1; rx_txnid = IW'(id); rx_kind = 2'(kind); rx_data = d;
        step(tag);
        rx_valid = 0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            summary();
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: outputs while reset is held
        chk("R1", "up_ready", up_ready, 1);
        chk("R1", "txreq_valid", txreq_valid, 0);
        chk("R1", "dn_valid", dn_valid, 0);
        rst_n = 1;
        txreq_ready = 1; dn_ready = 1;
        idle("R1", 2);

        // R2 read into slot 0, R4 write passes behind it
        send("R2", 0, 32'h100, 32'h0);
        send("R4", 1, 32'h200, 32'hAAAA);
        idle("R4", 2);
        // R5 second read is held until the receipt
        send("R5", 0, 32'h300, 32'h0);
        idle("R5", 3);
        give("R7", 0, 0, 32'h0);
        idle("R5", 2);
        give("R7", 0, 1, 32'hD00D);
        give("R7", 1, 2, 32'h0);
        // R7 data before receipt on slot 2
        give("R7", 2, 1, 32'hBEEF);
        give("R10", 2, 1, 32'hFFFF);
        idle("R7", 1);
        give("R7", 2, 0, 32'h0);
        idle("R9", 3);

        // R10 stray responses to a free slot
        give("R10", 5, 1, 32'h1234);
        give("R10", 5, 2, 32'h0);
        give("R10", 5, 3, 32'h0);
        idle("R10", 2);

        // R8 retry then reissue
        send("R8", 0, 32'h440, 32'h0);
        idle("R8", 2);
        give("R8", 0, 3, 32'h0);
        idle("R8", 3);
        give("R8", 0, 0, 32'h0);
        give("R8", 0, 1, 32'h5A5A);
        idle("R8", 3);

        // R3 fill every slot, then drain with round-robin R6 and R9
        txreq_ready = 0; dn_ready = 0;
        for (int i = 0; i < 10; i++) send("R3", i[0], 32'h1000 + i, 32'h70 + i);
        txreq_ready = 1;
        idle("R6", 10);
        for (int r = 0; r < 3; r++) begin
            for (int id = 0; id < N; id++) begin
                give("R7", id, 0, 32'h0);
                give("R7", id, 1, 32'hC000 + id);
                give("R7", id, 2, 32'h0);
            end
        end
        dn_ready = 1;
        idle("R9", 12);

        // Mixed random traffic
        for (int n = 0; n < 4000; n++) begin
            int r;
            up_valid = 1'($urandom % 2); up_write = 1'($urandom % 2);
            up_addr = $urandom; up_wdata = $urandom;
            txreq_ready = ($urandom % 4) != 0;
            dn_ready = ($urandom % 3) != 0;
            rx_valid = 1'($urandom % 2);
            rx_txnid = IW'($urandom % N);
            r = $urandom % 10;
            rx_kind = (r < 3) ? 2'd0 : (r < 6) ? 2'd1 : (r < 9) ? 2'd2 : 2'd3;
            rx_data = $urandom;
            step("R6");
        end
        up_valid = 0; rx_valid = 0;
        summary();
    end

endmodule